// File: doc/BRIEF.md
# Bank Address Demultiplexer and Region Decoder

This block is the glue between an 8/16-bit processor and its memories. The processor puts the top byte of a 24-bit address on the data bus during the low half of each bus cycle, and real data on the same wires during the high half. The block captures that bank byte while the phase input is low and holds it while the phase is high. It joins the bank byte with the 16-bit address bus into a 24-bit effective address, and decodes that address into active-low chip selects for RAM, a four-way split I/O window and a boot ROM.

Everything is clocked by a fast system clock that oversamples the phase input. A three-state sequencer follows the bus: `PH_IDLE` (after reset, until the first low phase), `PH_ADDR` (phase low, bank byte tracking the data bus) and `PH_DATA` (phase high, address frozen, selects live). Its transitions are IDLE→ADDR when the phase is seen low, ADDR→DATA when the phase is seen high (the effective address and the strobe state are captured on this transition), DATA→ADDR when the phase falls again, and a self-loop in each state otherwise. The selects are driven only in `PH_DATA`, and only when at least one valid-address strobe was high at capture.

The installed RAM is 512 KB: banks 00 to 07, with the I/O and ROM holes in bank 00 shadowing the RAM underneath. Banks 08 and up select nothing and raise an unmapped flag instead.

Top module: `bank_demux_decoder`

## Requirements
- R1: While `phase_i` is low, `bank_o` takes the value of `data_i` on each clock edge, so it shows the bank byte one clock after it is driven.
- R2: While `phase_i` is high, `bank_o` keeps its value whatever `data_i` carries.
- R3: On the first clock edge that sees `phase_i` high after a low phase, `eff_addr_o` becomes {`bank_o`, `addr_i`}. It does not change again while `phase_i` stays high.
- R4: If `vda_i` and `vpa_i` were both low at capture, no chip select is asserted and `unmapped_o` stays low for that bus cycle. Either strobe alone makes the cycle valid.
- R5: In bank 00, offsets 0000 to F7FF assert `ram_cs_n` low.
- R6: In bank 00, offsets F800 to FBFF assert exactly `io_cs_n[k]` low, where k is address bits 9:8 (F800 gives k=0, F900 gives k=1, FA00 gives k=2, FB00 gives k=3).
- R7: In bank 00, offsets FC00 to FFFF assert `rom_cs_n` low.
- R8: In banks 01 to 07, every offset asserts `ram_cs_n` low.
- R9: In banks 08 to FF, no select is asserted, and `unmapped_o` is high during a valid cycle.
- R10: At most one of `ram_cs_n`, `rom_cs_n`, the `io_cs_n` bits and `unmapped_o` is active at any time.
- R11: `ram_cs_n` returns high as soon as `phase_i` goes low. The I/O and ROM selects and `unmapped_o` stay active until the next clock edge, and all are inactive after that edge.
- R12: After reset, `bank_o` and `eff_addr_o` are zero, all selects are high and `unmapped_o` is low. No select is asserted until a full low-then-high phase has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus phase |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_i | input | 1 | Bus phase: low = address half, high = data half |
| addr_i | input | 16 | Low 16 address bits |
| data_i | input | 8 | Shared data bus; carries the bank byte while the phase is low |
| vda_i | input | 1 | Data-address valid strobe |
| vpa_i | input | 1 | Program-address valid strobe |
| bank_o | output | 8 | Captured bank byte |
| eff_addr_o | output | 24 | Effective address {bank, addr} held through the data half |
| ram_cs_n | output | 1 | RAM select, active low |
| rom_cs_n | output | 1 | Boot ROM select, active low |
| io_cs_n | output | 4 | I/O sub-window selects, active low, one per 256-byte slice |
| unmapped_o | output | 1 | High during a valid cycle to an address with no device |

## Verification
The bench walks the exact region edges (F7FF/F800, FBFF/FC00, bank 07 to 08, and the top of the map) with each strobe alone, with both strobes, and with neither. A decoder with an off-by-one limit would hand the boundary byte to the wrong device, and one that ignores the strobes would select on idle cycles. During the data half it drives different values on the data bus and expects the bank byte and the effective address not to move. A transparent latch left open would pick up the data value as a bank. At the falling phase it checks the single clock where RAM must already be released while I/O and ROM are still held. Swapping or merging those two timings shows up there as a wrong select.

// File: rtl/bank_dec_pkg.sv
package bank_dec_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } bus_phase_e;

    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_RAM  = 2'd1,
        RGN_IO   = 2'd2,
        RGN_ROM  = 2'd3
    } region_e;

endpackage

// File: rtl/bank_capture.sv
module bank_capture
    import bank_dec_pkg::*;
#(
    parameter int BANK_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     phase_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [BANK_W-1:0]        data_i,
    input  logic                     vda_i,
    input  logic                     vpa_i,
    output logic [BANK_W-1:0]        bank_o,
    output logic [BANK_W+ADDR_W-1:0] eff_o,
    output logic                     valid_o,
    output bus_phase_e               state_o
);

    localparam int EFF_W = BANK_W + ADDR_W;

    bus_phase_e              st_q, st_d;
    logic [BANK_W-1:0]       bank_q;
    logic [EFF_W-1:0]        eff_q;
    logic                    valid_q;
    logic                    capture;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PH_IDLE: st_d = phase_i ? PH_IDLE : PH_ADDR;
            PH_ADDR: st_d = phase_i ? PH_DATA : PH_ADDR;
            PH_DATA: st_d = phase_i ? PH_DATA : PH_ADDR;
            default: st_d = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PH_IDLE;
        else        st_q <= st_d;
    end

    assign capture = (st_q == PH_ADDR) && phase_i;

    // captured bus values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q  <= '0;
            eff_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            if (!phase_i) bank_q <= data_i;
            if (capture) begin
                eff_q   <= {bank_q, addr_i};
                valid_q <= vda_i | vpa_i;
            end
        end
    end

    assign bank_o  = bank_q;
    assign eff_o   = eff_q;
    assign valid_o = valid_q;
    assign state_o = st_q;

    // R2: the data half never disturbs the bank byte
    p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_i |=> $stable(bank_o));

    // R3: effective address frozen through the data half
    p_eff_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_DATA && phase_i) |=> $stable(eff_o));

    // R3: entering the data half carries the low address bits through
    p_eff_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_ADDR && phase_i) |=>
            (st_q == PH_DATA && eff_o[ADDR_W-1:0] == $past(addr_i)));

endmodule

// File: rtl/region_decode.sv
module region_decode
    import bank_dec_pkg::*;
#(
    parameter int              BANK_W     = 8,
    parameter int              ADDR_W     = 16,
    parameter int              RAM_BANKS  = 8,
    parameter logic [15:0]     IO_BASE    = 16'hF800,
    parameter logic [15:0]     ROM_BASE   = 16'hFC00,
    parameter int              IO_SUBS    = 4,
    parameter int              IO_SUB_LSB = 8
) (
    input  logic [BANK_W+ADDR_W-1:0]  eff_i,
    output region_e                   region_o,
    output logic [$clog2(IO_SUBS)-1:0] io_idx_o
);

    localparam int                IDX_W     = $clog2(IO_SUBS);
    localparam logic [BANK_W-1:0] RAM_LIMIT = BANK_W'(RAM_BANKS);
    localparam logic [ADDR_W-1:0] IO_LO     = ADDR_W'(IO_BASE);
    localparam logic [ADDR_W-1:0] ROM_LO    = ADDR_W'(ROM_BASE);

    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] off;
    region_e           rgn;

    assign bank = eff_i[ADDR_W +: BANK_W];
    assign off  = eff_i[ADDR_W-1:0];

    always_comb begin
        if (bank == '0) begin
            if (off >= ROM_LO)     rgn = RGN_ROM;
            else if (off >= IO_LO) rgn = RGN_IO;
            else                   rgn = RGN_RAM;
        end else if (bank < RAM_LIMIT) begin
            rgn = RGN_RAM;
        end else begin
            rgn = RGN_NONE;
        end
        // R9: banks beyond the installed RAM never map a device
        a_no_dev_r9: assert (bank < RAM_LIMIT || rgn == RGN_NONE);
    end

    assign region_o = rgn;
    assign io_idx_o = off[IO_SUB_LSB +: IDX_W];

endmodule

// File: rtl/select_drive.sv
module select_drive
    import bank_dec_pkg::*;
#(
    parameter int IO_SUBS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  bus_phase_e                 state_i,
    input  logic                       phase_i,
    input  logic                       valid_i,
    input  region_e                    region_i,
    input  logic [$clog2(IO_SUBS)-1:0] io_idx_i,
    output logic                       ram_cs_n,
    output logic                       rom_cs_n,
    output logic [IO_SUBS-1:0]         io_cs_n,
    output logic                       unmapped_o
);

    localparam int IDX_W = $clog2(IO_SUBS);

    logic live;

    always_comb begin
        live       = valid_i && (state_i == PH_DATA);
        ram_cs_n   = !(live && phase_i && region_i == RGN_RAM);
        rom_cs_n   = !(live && region_i == RGN_ROM);
        unmapped_o = live && region_i == RGN_NONE;
    end

    for (genvar g = 0; g < IO_SUBS; g++) begin : g_io
        assign io_cs_n[g] = !(live && region_i == RGN_IO && io_idx_i == IDX_W'(g));
    end

    // R10: never more than one active output
    p_one_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~ram_cs_n, ~rom_cs_n, ~io_cs_n, unmapped_o}));

    // R4: a cycle without strobes drives nothing
    p_no_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> (ram_cs_n && rom_cs_n && (&io_cs_n) && !unmapped_o));

    // R11: RAM released once the phase has fallen
    p_ram_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_i |-> ram_cs_n);

    // R12: selects only in the data half
    p_data_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i != PH_DATA) |-> (ram_cs_n && rom_cs_n && (&io_cs_n)));

endmodule

// File: rtl/bank_demux_decoder.sv
module bank_demux_decoder
    import bank_dec_pkg::*;
#(
    parameter int          BANK_W     = 8,
    parameter int          ADDR_W     = 16,
    parameter int          RAM_BANKS  = 8,
    parameter logic [15:0] IO_BASE    = 16'hF800,
    parameter logic [15:0] ROM_BASE   = 16'hFC00,
    parameter int          IO_SUBS    = 4,
    parameter int          IO_SUB_LSB = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     phase_i,
    input  logic [ADDR_W-1:0]        addr_i,
    input  logic [BANK_W-1:0]        data_i,
    input  logic                     vda_i,
    input  logic                     vpa_i,
    output logic [BANK_W-1:0]        bank_o,
    output logic [BANK_W+ADDR_W-1:0] eff_addr_o,
    output logic                     ram_cs_n,
    output logic                     rom_cs_n,
    output logic [IO_SUBS-1:0]       io_cs_n,
    output logic                     unmapped_o
);

    localparam int IDX_W = $clog2(IO_SUBS);

    bus_phase_e       state;
    logic             valid;
    region_e          region;
    logic [IDX_W-1:0] io_idx;

    bank_capture #(
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .phase_i (phase_i),
        .addr_i  (addr_i),
        .data_i  (data_i),
        .vda_i   (vda_i),
        .vpa_i   (vpa_i),
        .bank_o  (bank_o),
        .eff_o   (eff_addr_o),
        .valid_o (valid),
        .state_o (state)
    );

    region_decode #(
        .BANK_W     (BANK_W),
        .ADDR_W     (ADDR_W),
        .RAM_BANKS  (RAM_BANKS),
        .IO_BASE    (IO_BASE),
        .ROM_BASE   (ROM_BASE),
        .IO_SUBS    (IO_SUBS),
        .IO_SUB_LSB (IO_SUB_LSB)
    ) u_decode (
        .eff_i    (eff_addr_o),
        .region_o (region),
        .io_idx_o (io_idx)
    );

    select_drive #(
        .IO_SUBS (IO_SUBS)
    ) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_i    (state),
        .phase_i    (phase_i),
        .valid_i    (valid),
        .region_i   (region),
        .io_idx_i   (io_idx),
        .ram_cs_n   (ram_cs_n),
        .rom_cs_n   (rom_cs_n),
        .io_cs_n    (io_cs_n),
        .unmapped_o (unmapped_o)
    );

endmodule

// File: tb/test_bank_demux_decoder.sv
module test_bank_demux_decoder;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_i = 1'b1;
    logic [15:0] addr_i = '0;
    logic [7:0]  data_i = '0;
    logic        vda_i = 1'b0;
    logic        vpa_i = 1'b0;
    logic [7:0]  bank_o;
    logic [23:0] eff_addr_o;
    logic        ram_cs_n, rom_cs_n, unmapped_o;
    logic [3:0]  io_cs_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    bank_demux_decoder i_bank_demux_decoder (
        .clk(clk), .rst_n(rst_n), .phase_i(phase_i), .addr_i(addr_i),
        .data_i(data_i), .vda_i(vda_i), .vpa_i(vpa_i), .bank_o(bank_o),
        .eff_addr_o(eff_addr_o), .ram_cs_n(ram_cs_n), .rom_cs_n(rom_cs_n),
        .io_cs_n(io_cs_n), .unmapped_o(unmapped_o)
    );

    // active-high view: [6]=unmapped [5]=ram [4]=rom [3:0]=io slice
    function automatic logic [6:0] sel_now();
        return {unmapped_o, ~ram_cs_n, ~rom_cs_n, ~io_cs_n};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // {bank, addr, vda, vpa, expected selects}
    localparam int NV = 16;
    localparam logic [32:0] VEC [NV] = '{
        {8'h00, 16'h0000, 1'b1, 1'b0, 7'b0100000},
        {8'h00, 16'hF7FF, 1'b0, 1'b1, 7'b0100000},
        {8'h00, 16'hF800, 1'b1, 1'b0, 7'b0000001},
        {8'h00, 16'hF9AB, 1'b1, 1'b0, 7'b0000010},
        {8'h00, 16'hFA00, 1'b0, 1'b1, 7'b0000100},
        {8'h00, 16'hFBFF, 1'b1, 1'b0, 7'b0001000},
        {8'h00, 16'hFC00, 1'b1, 1'b0, 7'b0010000},
        {8'h00, 16'hFFFF, 1'b0, 1'b1, 7'b0010000},
        {8'h01, 16'h0000, 1'b1, 1'b0, 7'b0100000},
        {8'h07, 16'hFFFF, 1'b1, 1'b1, 7'b0100000},
        {8'h08, 16'h0000, 1'b1, 1'b0, 7'b1000000},
        {8'hFF, 16'h1234, 1'b1, 1'b1, 7'b1000000},
        {8'h03, 16'h4567, 1'b0, 1'b0, 7'b0000000},
        {8'h00, 16'hFC00, 1'b0, 1'b0, 7'b0000000},
        {8'h00, 16'hF800, 1'b1, 1'b1, 7'b0000001},
        {8'h05, 16'hF900, 1'b0, 1'b1, 7'b0100000}
    };

    function automatic string tag_of(input logic [7:0] bk, input logic [6:0] e);
        if (e == 7'd0)      return "R4";
        if (e[6])           return "R9";
        if (e[4])           return "R7";
        if (e[5] && bk == 0) return "R5";
        if (e[5])           return "R8";
        return "R6";
    endfunction

    task automatic bus_cycle(input logic [7:0] bk, input logic [15:0] ad,
                             input logic dv, input logic pv, input logic [6:0] e);
        string t;
        t = tag_of(bk, e);
        @(negedge clk);
        phase_i = 1'b0; data_i = bk; addr_i = ad; vda_i = dv; vpa_i = pv;
        @(negedge clk);
        @(negedge clk);
        phase_i = 1'b1; data_i = ~bk;
        @(negedge clk);
        chk(32'(sel_now()), 32'(e), t, "select");
        chk(32'($countones(sel_now()) <= 1), 32'd1, "R10", "one active");
        chk(32'(eff_addr_o), 32'({bk, ad}), "R3", "eff addr");
        chk(32'(bank_o), 32'(bk), "R2", "bank hold");
        data_i = 8'hC3 ^ bk;
        @(negedge clk);
        chk(32'(bank_o), 32'(bk), "R2", "bank hold 2");
        chk(32'(eff_addr_o), 32'({bk, ad}), "R3", "eff stable");
        phase_i = 1'b0; data_i = 8'h00;
        #1;
        chk(32'(sel_now()), 32'(e & 7'b1011111), "R11", "phase fall");
        @(negedge clk);
        chk(32'(sel_now()), 32'd0, "R11", "after fall");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        vda_i = 1'b1; vpa_i = 1'b1; data_i = 8'h55;
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset values, and nothing selected before a full low/high phase
        chk(32'(bank_o), 32'd0, "R12", "reset bank");
        chk(32'(eff_addr_o), 32'd0, "R12", "reset eff");
        chk(32'(sel_now()), 32'd0, "R12", "reset selects");

        for (int i = 0; i < NV; i++)
            bus_cycle(VEC[i][32:25], VEC[i][24:9], VEC[i][8], VEC[i][7], VEC[i][6:0]);

        // R1: bank follows the data bus while the phase is low
        @(negedge clk);
        phase_i = 1'b0; data_i = 8'h3C;
        @(negedge clk);
        chk(32'(bank_o), 32'h3C, "R1", "bank follow");
        data_i = 8'hA5;
        @(negedge clk);
        chk(32'(bank_o), 32'hA5, "R1", "bank follow 2");
        // R2: data-half values are not taken as bank
        phase_i = 1'b1; data_i = 8'hFF;
        @(negedge clk);
        chk(32'(bank_o), 32'hA5, "R2", "no sample high");

        // R12: reset during an active cycle clears everything
        bus_cycle(8'h00, 16'hFC10, 1'b1, 1'b0, 7'b0010000);
        phase_i = 1'b0; data_i = 8'h02; addr_i = 16'h0100;
        repeat (2) @(negedge clk);
        phase_i = 1'b1;
        @(negedge clk);
        chk(32'(sel_now()), 32'h20, "R8", "pre-reset ram");
        rst_n = 1'b0;
        @(negedge clk);
        chk(32'(sel_now()), 32'd0, "R12", "mid reset selects");
        chk(32'(eff_addr_o), 32'd0, "R12", "mid reset eff");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule